// File: doc/BRIEF.md
# Two-Word Message Mailbox

This block passes short messages between a host processor and an embedded engine. Traffic from the host to the engine goes through an inbound queue, and traffic from the engine to the host goes through an outbound queue. The host sees four word registers: a data port, a status register, a control register and a mailbox register.

A host write to the data port pushes onto the inbound queue. A host read of the data port pops the outbound queue. The engine uses plain strobes: one pops the inbound queue, one pushes the outbound queue, and one loads the mailbox. A message is always two 32-bit words, so each queue holds at least two words.

Three interrupt sources drive a single request line. The first rises when the inbound queue has drained. The second rises when a whole message is waiting in the outbound queue. The third rises when the engine has written the mailbox.

Top module: `msg_mailbox`

## Requirements
- R1: After reset the status register reads 0x00060000, the control register reads 0, the mailbox reads 0x0000F0F0, `irq` is 0 and `e_rdata` is 0.
- R2: The host register index `h_addr` is decoded as 0 = data, 1 = status, 2 = control, 3 = mailbox. When the inbound queue is enabled, a host write to index 0 pushes `h_wdata`. Each `e_rd` pulse pops one word, and `e_rdata` shows the head word in arrival order.
- R3: When the outbound queue is enabled, `e_wr` pushes `e_wdata`. A host read of index 0 returns the head word on `h_rdata` in that cycle and pops it, so words come out in arrival order.
- R4: The status bits report queue state as follows: bit 16 = outbound not empty, bit 17 = inbound not full, bit 18 = outbound not full, bit 19 = inbound not empty.
- R5: With the default depth of 4, inbound not-full stays 1 after one word and after two words. It drops to 0 after four words.
- R6: A push to a full queue is dropped and the contents do not change. The push sets a sticky overflow flag: status bit 0 for the inbound queue and bit 1 for the outbound queue. Writing 1 to the flag's bit in the status register clears it.
- R7: Popping an empty queue returns 0 and leaves the read position unchanged. The next word pushed is the next word popped.
- R8: Control bit 16 enables the outbound queue and bit 17 enables the inbound queue. While a queue is disabled, its pushes and pops have no effect. Control bit 24 enables the outbound interrupt and bit 25 enables the inbound interrupt. All other control bits read 0.
- R9: Status bit 21 equals control bit 25 AND the inbound queue being empty. Status bit 22 equals control bit 24 AND the outbound queue holding at least two words. Status bit 23 reads 0. `irq` is the OR of status bits 20 to 22.
- R10: The mailbox register loads a host write to index 3. It also loads `e_wdata` on `e_mbox_wr`, and the engine load wins if both happen together. An engine load sets the sticky status bit 20, and writing 1 to bit 20 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| h_addr | input | 2 | Host register index |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe (pops when index is 0) |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data for the selected register |
| e_wr | input | 1 | Engine push to the outbound queue |
| e_wdata | input | DW | Engine write data (queue and mailbox) |
| e_rd | input | 1 | Engine pop from the inbound queue |
| e_rdata | output | DW | Head of the inbound queue, 0 when empty |
| e_mbox_wr | input | 1 | Engine load of the mailbox register |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions are checked on every cycle. They cover the following:
- Neither queue's fill level ever exceeds its depth.
- An accepted push grows the fill level by one.
- A push into a full queue sets the overflow flag, and the flag then holds until it is written with 1.
- An empty pop leaves the read position alone.
- A disabled queue never changes.
- An engine mailbox load always raises bit 20.

Some behaviour can only be shown by the bench scenarios:
- words leave each queue in the order they arrived;
- the word dropped on overflow is the last one, not the first;
- the status encoding is correct as a whole;
- the interrupt line follows the enables.

// File: rtl/msg_mailbox.sv
module msg_mailbox #(
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter logic [31:0] MBOX_INIT = 32'h0000_F0F0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    h_addr,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic          e_wr,
  input  logic [DW-1:0] e_wdata,
  input  logic          e_rd,
  output logic [DW-1:0] e_rdata,
  input  logic          e_mbox_wr,
  output logic          irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [CW-1:0] MSG_WORDS = CW'(2);
  localparam logic [1:0] IX_DATA = 2'd0, IX_STAT = 2'd1, IX_CTRL = 2'd2, IX_MBOX = 2'd3;
  localparam int B_IOVF = 0, B_OOVF = 1;
  localparam int B_ONE = 16, B_INF = 17, B_ONF = 18, B_INE = 19;
  localparam int B_MBI = 20, B_INI = 21, B_OUI = 22, B_WTI = 23;
  localparam int C_OEN = 16, C_IEN = 17, C_OIE = 24, C_IIE = 25;

  logic [DW-1:0] in_mem  [DEPTH];
  logic [DW-1:0] out_mem [DEPTH];
  logic [AW-1:0] in_wp, in_rp, out_wp, out_rp;
  logic [CW-1:0] in_cnt, out_cnt;
  logic          in_ovf, out_ovf, mb_flag;
  logic          ctl_out_en, ctl_in_en, ctl_out_ie, ctl_in_ie;
  logic [DW-1:0] mbox;
  logic [DW-1:0] status, control;

  wire h_data_wr = h_wr && h_addr == IX_DATA;
  wire h_data_rd = h_rd && h_addr == IX_DATA;
  wire h_stat_wr = h_wr && h_addr == IX_STAT;

  wire in_empty  = in_cnt == '0;
  wire in_full   = in_cnt == FULL;
  wire out_empty = out_cnt == '0;
  wire out_full  = out_cnt == FULL;

  wire in_req  = h_data_wr && ctl_in_en;
  wire in_push = in_req && !in_full;
  wire in_pop  = e_rd && ctl_in_en && !in_empty;
  wire out_req  = e_wr && ctl_out_en;
  wire out_push = out_req && !out_full;
  wire out_pop  = h_data_rd && ctl_out_en && !out_empty;

  wire in_irq  = ctl_in_ie && in_empty;
  wire out_irq = ctl_out_ie && out_cnt >= MSG_WORDS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_wp <= '0; in_rp <= '0; in_cnt <= '0;
    end else begin
      if (in_push) in_wp <= in_wp + 1'b1;
      if (in_pop)  in_rp <= in_rp + 1'b1;
      in_cnt <= in_cnt + CW'(in_push) - CW'(in_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_wp <= '0; out_rp <= '0; out_cnt <= '0;
    end else begin
      if (out_push) out_wp <= out_wp + 1'b1;
      if (out_pop)  out_rp <= out_rp + 1'b1;
      out_cnt <= out_cnt + CW'(out_push) - CW'(out_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (in_push)  in_mem[in_wp]   <= h_wdata;
    if (out_push) out_mem[out_wp] <= e_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ovf <= 1'b0; out_ovf <= 1'b0; mb_flag <= 1'b0;
    end else begin
      in_ovf  <= (in_ovf  && !(h_stat_wr && h_wdata[B_IOVF])) || (in_req && in_full);
      out_ovf <= (out_ovf && !(h_stat_wr && h_wdata[B_OOVF])) || (out_req && out_full);
      mb_flag <= (mb_flag && !(h_stat_wr && h_wdata[B_MBI])) || e_mbox_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {ctl_in_ie, ctl_out_ie, ctl_in_en, ctl_out_en} <= '0;
    end else if (h_wr && h_addr == IX_CTRL) begin
      {ctl_in_ie, ctl_out_ie, ctl_in_en, ctl_out_en} <=
        {h_wdata[C_IIE], h_wdata[C_OIE], h_wdata[C_IEN], h_wdata[C_OEN]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          mbox <= DW'(MBOX_INIT);
    else if (e_mbox_wr)                  mbox <= e_wdata;
    else if (h_wr && h_addr == IX_MBOX)  mbox <= h_wdata;
  end

  always_comb begin
    status = '0;
    status[B_IOVF] = in_ovf;
    status[B_OOVF] = out_ovf;
    status[B_ONE]  = !out_empty;
    status[B_INF]  = !in_full;
    status[B_ONF]  = !out_full;
    status[B_INE]  = !in_empty;
    status[B_MBI]  = mb_flag;
    status[B_INI]  = in_irq;
    status[B_OUI]  = out_irq;
    status[B_WTI]  = 1'b0;
    control = '0;
    control[C_OEN] = ctl_out_en;
    control[C_IEN] = ctl_in_en;
    control[C_OIE] = ctl_out_ie;
    control[C_IIE] = ctl_in_ie;
  end

  always_comb begin
    unique case (h_addr)
      IX_DATA: h_rdata = out_empty ? '0 : out_mem[out_rp];
      IX_STAT: h_rdata = status;
      IX_CTRL: h_rdata = control;
      default: h_rdata = mbox;
    endcase
  end

  assign e_rdata = in_empty ? '0 : in_mem[in_rp];
  assign irq = mb_flag || in_irq || out_irq;
endmodule

// File: rtl/msg_mailbox_chk.sv
module msg_mailbox_chk #(
  parameter int DW = 32,
  parameter int DEPTH = 4,
  parameter int AW = 2,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    h_addr,
  input logic          h_wr,
  input logic          h_rd,
  input logic [DW-1:0] h_wdata,
  input logic          e_wr,
  input logic          e_rd,
  input logic          e_mbox_wr,
  input logic [CW-1:0] in_cnt,
  input logic [CW-1:0] out_cnt,
  input logic [AW-1:0] out_rp,
  input logic          in_ovf,
  input logic          mb_flag,
  input logic          ctl_in_en,
  input logic          ctl_out_en
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    in_cnt <= FULL && out_cnt <= FULL);

  a_r2_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 2'd0 && ctl_in_en && in_cnt < FULL && !e_rd)
    |=> in_cnt == $past(in_cnt) + 1'b1);

  a_r6_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_addr == 2'd0 && ctl_in_en && in_cnt == FULL) |=> in_ovf);

  a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ovf && !(h_wr && h_addr == 2'd1 && h_wdata[0])) |=> in_ovf);

  a_r7_empty_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_addr == 2'd0 && out_cnt == '0 && !e_wr)
    |=> $stable(out_rp) && out_cnt == '0);

  a_r8_in_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_in_en |=> $stable(in_cnt));

  a_r8_out_disabled_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_out_en |=> $stable(out_cnt));

  a_r10_mbox_flag: assert property (@(posedge clk) disable iff (!rst_n)
    e_mbox_wr |=> mb_flag);
endmodule

bind msg_mailbox msg_mailbox_chk #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
  .h_wdata(h_wdata), .e_wr(e_wr), .e_rd(e_rd), .e_mbox_wr(e_mbox_wr),
  .in_cnt(in_cnt), .out_cnt(out_cnt), .out_rp(out_rp), .in_ovf(in_ovf),
  .mb_flag(mb_flag), .ctl_in_en(ctl_in_en), .ctl_out_en(ctl_out_en)
);

// File: tb/msg_mailbox_bench.sv
module msg_mailbox_bench;
  localparam int DW = 32;
  localparam logic [2:0] HW = 3'd0, HR = 3'd1, EW = 3'd2, ER = 3'd3, PK = 3'd4;
  localparam int NV = 15;
  localparam logic [68:0] VEC [NV] = '{
    {HW, 2'd2, 32'h0303_0000, 32'h0},
    {PK, 2'd1, 32'h0,         32'h0026_0000},
    {HW, 2'd0, 32'h1111_1111, 32'h0},
    {PK, 2'd1, 32'h0,         32'h000E_0000},
    {HW, 2'd0, 32'h2222_2222, 32'h0},
    {ER, 2'd0, 32'h0,         32'h1111_1111},
    {ER, 2'd0, 32'h0,         32'h2222_2222},
    {EW, 2'd0, 32'hAAAA_0001, 32'h0},
    {PK, 2'd1, 32'h0,         32'h0027_0000},
    {EW, 2'd0, 32'hAAAA_0002, 32'h0},
    {PK, 2'd1, 32'h0,         32'h0067_0000},
    {HR, 2'd0, 32'h0,         32'hAAAA_0001},
    {HR, 2'd0, 32'h0,         32'hAAAA_0002},
    {PK, 2'd2, 32'h0,         32'h0303_0000},
    {PK, 2'd3, 32'h0,         32'h0000_F0F0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] h_addr = '0;
  logic h_wr = 1'b0, h_rd = 1'b0, e_wr = 1'b0, e_rd = 1'b0, e_mbox_wr = 1'b0;
  logic [DW-1:0] h_wdata = '0, e_wdata = '0;
  logic [DW-1:0] h_rdata, e_rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic [DW-1:0] got;

  always #4 clk = ~clk;

  msg_mailbox u_msg_mailbox (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wr(h_wr), .h_rd(h_rd),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .e_wr(e_wr), .e_wdata(e_wdata),
    .e_rd(e_rd), .e_rdata(e_rdata), .e_mbox_wr(e_mbox_wr), .irq(irq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    h_wr = 0; h_rd = 0; e_wr = 0; e_rd = 0; e_mbox_wr = 0;
  endtask

  task automatic hwr(input logic [1:0] a, input logic [DW-1:0] d);
    h_addr = a; h_wdata = d; h_wr = 1; idle();
  endtask

  task automatic hrd(input logic [1:0] a, output logic [DW-1:0] d);
    h_addr = a; h_rd = 1; #1 d = h_rdata; idle();
  endtask

  task automatic peek(input logic [1:0] a, output logic [DW-1:0] d);
    h_addr = a; #1 d = h_rdata;
  endtask

  task automatic ewr(input logic [DW-1:0] d);
    e_wdata = d; e_wr = 1; idle();
  endtask

  task automatic erd(output logic [DW-1:0] d);
    e_rd = 1; #1 d = e_rdata; idle();
  endtask

  task automatic run_vec(input int i);
    logic [2:0] op;
    logic [1:0] a;
    logic [DW-1:0] d, x;
    {op, a, d, x} = VEC[i];
    case (op)
      HW: hwr(a, d);
      EW: ewr(d);
      HR: begin hrd(a, got); chk($sformatf("R3 vec%0d", i), got, x); end
      ER: begin erd(got); chk($sformatf("R2 vec%0d", i), got, x); end
      default: begin peek(a, got); chk($sformatf("R4 R9 vec%0d", i), got, x); end
    endcase
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(2'd1, got); chk("R1 status", got, 32'h0006_0000);
    peek(2'd2, got); chk("R1 control", got, 32'h0);
    peek(2'd3, got); chk("R1 mailbox", got, 32'h0000_F0F0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 e_rdata", e_rdata, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R6 R5 inbound overflow: fifth word dropped
    for (int i = 0; i < 5; i++) hwr(2'd0, 32'hB000_0000 + i);
    peek(2'd1, got); chk("R6 R5 inbound full status", got, 32'h000C_0001);
    for (int i = 0; i < 4; i++) begin
      erd(got); chk("R6 inbound order after drop", got, 32'hB000_0000 + i);
    end
    erd(got); chk("R7 empty engine pop", got, 32'h0);
    hwr(2'd1, 32'h0000_0001);
    peek(2'd1, got); chk("R6 inbound overflow cleared", got, 32'h0026_0000);

    // R6 outbound overflow, R7 empty host pop
    for (int i = 0; i < 5; i++) ewr(32'hC000_0000 + i);
    peek(2'd1, got); chk("R6 outbound full status", got, 32'h0063_0002);
    for (int i = 0; i < 4; i++) begin
      hrd(2'd0, got); chk("R6 outbound order after drop", got, 32'hC000_0000 + i);
    end
    hrd(2'd0, got); chk("R7 empty host pop", got, 32'h0);
    ewr(32'h0000_0055);
    hrd(2'd0, got); chk("R7 next word after empty pop", got, 32'h0000_0055);
    hwr(2'd1, 32'h0000_0002);
    peek(2'd1, got); chk("R6 outbound overflow cleared", got, 32'h0026_0000);

    // R8 disabled queues ignore push and pop
    hwr(2'd0, 32'hD000_0001);
    hwr(2'd2, 32'h0000_0000);
    erd(got);
    hwr(2'd0, 32'hD000_0002);
    ewr(32'hD000_0003);
    peek(2'd1, got); chk("R8 disabled keeps one inbound word", got, 32'h000E_0000);
    chk("R9 irq low with interrupts disabled", {31'b0, irq}, 32'h0);
    hwr(2'd2, 32'hFFFF_FFFF);
    peek(2'd2, got); chk("R8 control reserved bits", got, 32'h0303_0000);
    erd(got); chk("R8 word survives disabled pop", got, 32'hD000_0001);
    chk("R9 irq on inbound drained", {31'b0, irq}, 32'h1);
    hwr(2'd2, 32'h0000_0000);

    // R10 mailbox
    hwr(2'd3, 32'h1234_5678);
    peek(2'd3, got); chk("R10 host mailbox write", got, 32'h1234_5678);
    e_wdata = 32'hCAFE_0000; e_mbox_wr = 1; idle();
    peek(2'd3, got); chk("R10 engine mailbox write", got, 32'hCAFE_0000);
    peek(2'd1, got); chk("R10 mailbox flag", got, 32'h0016_0000);
    chk("R9 irq from mailbox", {31'b0, irq}, 32'h1);
    hwr(2'd1, 32'h0010_0000);
    peek(2'd1, got); chk("R10 mailbox flag cleared", got, 32'h0006_0000);
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule